// File: doc/BRIEF.md
# Output Driver Impedance Trim Stepper

This block is the digital control loop that keeps a programmable output driver at its target impedance. It holds two unsigned binary-weighted trim codes, one for the pull-up leg and one for the pull-down leg. A free-running cycle counter starts an evaluation once per period. At each evaluation the block reads a pair of comparator flags for each leg: one asks for a stronger code and one asks for a weaker code. It then works out a candidate code that is at most one step away from the committed code.

A candidate is not committed at once. It waits as a pending update until its leg is idle. The pull-down code may change only while the pad drives a 1 or is in high impedance. The pull-up code may change only while the pad drives a 0 or is in high impedance. A later evaluation always overwrites a pending candidate that is still waiting. Each code saturates at both ends of its range.

Top module: `drive_trim_stepper`

## Requirements
- R1: While reset is asserted (rstN low), and after it is released until the first update, both codes hold midscale, 2^(CODE_W-1) (4 for CODE_W=3).
- R2: An evaluation samples the comparator flags on the PERIOD-th rising clock edge after reset release, and then on every PERIOD-th edge after that.
- R3: At an evaluation, a leg's candidate is committed+1 when only its increment flag is high and committed-1 when only its decrement flag is high. When both flags or neither flag is high, the code stays where it is and any waiting candidate is dropped.
- R4: A code never goes above 2^CODE_W-1 or below 0, and never wraps from one end to the other.
- R5: The pull-down code changes only on an edge where drvEn is 0 or drvData is 1.
- R6: The pull-up code changes only on an edge where drvEn is 0 or drvData is 0.
- R7: A waiting candidate stays held until its leg's apply condition holds. A newer evaluation replaces it with a candidate computed from the committed code, so the committed code never moves more than one step per commit.
- R8: Comparator flags have no effect on any edge other than an evaluation edge.
- R9: A candidate is committed on the first rising edge after its evaluation edge on which the apply condition holds. It is never committed on the evaluation edge itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| drvEn | input | 1 | Pad output enable; 0 means high impedance |
| drvData | input | 1 | Value the pad drives when enabled |
| puIncReq | input | 1 | Pull-up comparator asks for a stronger code |
| puDecReq | input | 1 | Pull-up comparator asks for a weaker code |
| pdIncReq | input | 1 | Pull-down comparator asks for a stronger code |
| pdDecReq | input | 1 | Pull-down comparator asks for a weaker code |
| puCode | output | CODE_W | Committed pull-up trim code |
| pdCode | output | CODE_W | Committed pull-down trim code |

## Verification
Comparator flags matter only on the evaluation edge, which is the PERIOD-th rising edge after reset release. The resulting code becomes visible no earlier than one edge after that, on the first edge where the leg is idle. The bench drives inputs on falling edges and updates its own cycle model at each rising edge from the requirements. It compares both codes on the following falling edge, so every result is checked in the exact cycle it is due. Directed checks line up with the model's evaluation edges to test the one-cycle commit delay, the replacement of a waiting candidate, and the fact that flags between evaluations are ignored.

// File: rtl/drive_trim_pkg.sv
package drive_trim_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic evalTick;   // evaluation edge: sample comparators, rebuild candidates
    logic puApply;    // pull-up leg idle and no evaluation this edge
    logic pdApply;    // pull-down leg idle and no evaluation this edge
  } trimStrobe_t;

  localparam int unsigned LEG_PU = 0;
  localparam int unsigned LEG_PD = 1;
  localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/drive_trim_ctrl.sv
module drive_trim_ctrl
  import drive_trim_pkg::*;
#(
  parameter int unsigned PERIOD = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        drvEn,
  input  logic        drvData,
  output trimStrobe_t strobe
);

  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             atLast;

  assign atLast = (tickCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (atLast) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // Evaluation takes precedence; commits wait for a non-evaluation edge
  always_comb begin
    strobe.evalTick = atLast;
    strobe.puApply  = !atLast && (!drvEn || !drvData);
    strobe.pdApply  = !atLast && (!drvEn ||  drvData);
  end

endmodule

// File: rtl/drive_trim_leg.sv
module drive_trim_leg #(
  parameter int unsigned         CODE_W     = 4,
  parameter logic [CODE_W-1:0]   RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalTick,
  input  logic              applyOk,
  input  logic              incReq,
  input  logic              decReq,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [CODE_W-1:0] pendCode;
  logic [CODE_W-1:0] stepCode;
  logic              pendValid;

  // One saturating step from the committed code
  always_comb begin
    stepCode = code;
    if (incReq && !decReq && (code != CODE_MAX)) begin
      stepCode = code + 1'b1;
    end else if (decReq && !incReq && (code != CODE_MIN)) begin
      stepCode = code - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code      <= RESET_CODE;
      pendCode  <= RESET_CODE;
      pendValid <= 1'b0;
    end else if (evalTick) begin
      pendCode  <= stepCode;
      pendValid <= (stepCode != code);
    end else if (pendValid && applyOk) begin
      code      <= pendCode;
      pendValid <= 1'b0;
    end
  end

endmodule

// File: rtl/drive_trim_datapath.sv
module drive_trim_datapath
  import drive_trim_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  trimStrobe_t                       strobe,
  input  logic [NUM_LEGS-1:0]               incReq,
  input  logic [NUM_LEGS-1:0]               decReq,
  output logic [NUM_LEGS-1:0][CODE_W-1:0]   codes
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [NUM_LEGS-1:0] applyOk;

  always_comb begin
    applyOk         = '0;
    applyOk[LEG_PU] = strobe.puApply;
    applyOk[LEG_PD] = strobe.pdApply;
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    drive_trim_leg #(
      .CODE_W     (CODE_W),
      .RESET_CODE (MID_CODE)
    ) uLeg (
      .clk      (clk),
      .rstN     (rstN),
      .evalTick (strobe.evalTick),
      .applyOk  (applyOk[g]),
      .incReq   (incReq[g]),
      .decReq   (decReq[g]),
      .code     (codes[g])
    );
  end

endmodule

// File: rtl/drive_trim_stepper.sv
module drive_trim_stepper
  import drive_trim_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned PERIOD = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drvEn,
  input  logic              drvData,
  input  logic              puIncReq,
  input  logic              puDecReq,
  input  logic              pdIncReq,
  input  logic              pdDecReq,
  output logic [CODE_W-1:0] puCode,
  output logic [CODE_W-1:0] pdCode
);

  trimStrobe_t                     strobe;
  logic [NUM_LEGS-1:0]             incReq;
  logic [NUM_LEGS-1:0]             decReq;
  logic [NUM_LEGS-1:0][CODE_W-1:0] codes;

  always_comb begin
    incReq         = '0;
    decReq         = '0;
    incReq[LEG_PU] = puIncReq;
    decReq[LEG_PU] = puDecReq;
    incReq[LEG_PD] = pdIncReq;
    decReq[LEG_PD] = pdDecReq;
  end

  drive_trim_ctrl #(.PERIOD(PERIOD)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .drvEn   (drvEn),
    .drvData (drvData),
    .strobe  (strobe)
  );

  drive_trim_datapath #(.CODE_W(CODE_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .incReq (incReq),
    .decReq (decReq),
    .codes  (codes)
  );

  assign puCode = codes[LEG_PU];
  assign pdCode = codes[LEG_PD];

endmodule

// File: rtl/drive_trim_checks.sv
module drive_trim_checks
  import drive_trim_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned PERIOD = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              drvEn,
  input logic              drvData,
  input logic [CODE_W-1:0] puCode,
  input logic [CODE_W-1:0] pdCode,
  input trimStrobe_t       strobe
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  int unsigned gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.evalTick) gapCnt <= 0;
    else                          gapCnt <= gapCnt + 1;
  end

  // R2: evaluations exactly PERIOD edges apart
  a_r2_period: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalTick |-> (gapCnt == PERIOD - 1));

  // R3 / R7: a commit moves a code by exactly one step
  a_r3_pu_one_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(puCode) |-> (int'(puCode) == int'($past(puCode)) + 1 ||
                          int'(puCode) + 1 == int'($past(puCode))));
  a_r7_pd_one_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pdCode) |-> (int'(pdCode) == int'($past(pdCode)) + 1 ||
                          int'(pdCode) + 1 == int'($past(pdCode))));

  // R4: no wrap at either end
  a_r4_pu_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(puCode) == CODE_MAX) |-> (puCode != '0));
  a_r4_pd_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pdCode) == '0) |-> (pdCode != CODE_MAX));

  // R5 / R6: leg changes only while idle
  a_r5_pd_gate: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pdCode) |-> $past(!drvEn || drvData));
  a_r6_pu_gate: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(puCode) |-> $past(!drvEn || !drvData));

  // R9: never committed on the evaluation edge
  a_r9_pu_not_on_eval: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(puCode) |-> !$past(strobe.evalTick));
  a_r9_pd_not_on_eval: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pdCode) |-> !$past(strobe.evalTick));

endmodule

bind drive_trim_stepper drive_trim_checks #(
  .CODE_W (CODE_W),
  .PERIOD (PERIOD)
) uChecks (
  .clk     (clk),
  .rstN    (rstN),
  .drvEn   (drvEn),
  .drvData (drvData),
  .puCode  (puCode),
  .pdCode  (pdCode),
  .strobe  (strobe)
);

// File: tb/drive_trim_stepper_test.sv
module drive_trim_stepper_test;

  localparam int CODE_W = 3;
  localparam int PERIOD = 5;
  localparam int CMAX   = (1 << CODE_W) - 1;
  localparam int MID    = 1 << (CODE_W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drvEn = 1'b0, drvData = 1'b0;
  logic puInc = 1'b0, puDec = 1'b0, pdInc = 1'b0, pdDec = 1'b0;
  logic [CODE_W-1:0] puCode, pdCode;

  int checks = 0;
  int errors = 0;

  // Reference state
  int mCnt = 0;
  int mPu = MID, mPd = MID;
  int mPuPend = MID, mPdPend = MID;
  bit mPuPendV = 0, mPdPendV = 0;
  bit mLastEval = 0;

  always #10 clk = ~clk;

  drive_trim_stepper #(.CODE_W(CODE_W), .PERIOD(PERIOD)) uut (
    .clk(clk), .rstN(rstN), .drvEn(drvEn), .drvData(drvData),
    .puIncReq(puInc), .puDecReq(puDec), .pdIncReq(pdInc), .pdDecReq(pdDec),
    .puCode(puCode), .pdCode(pdCode)
  );

  function automatic int satStep(int c, bit inc, bit dec);
    if (inc && !dec) return (c < CMAX) ? c + 1 : c;
    if (dec && !inc) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    int nxt;
    mLastEval = (mCnt == PERIOD - 1);
    mCnt = mLastEval ? 0 : mCnt + 1;
    if (mLastEval) begin
      nxt = satStep(mPu, puInc, puDec); mPuPendV = (nxt != mPu); mPuPend = nxt;
      nxt = satStep(mPd, pdInc, pdDec); mPdPendV = (nxt != mPd); mPdPend = nxt;
    end else begin
      if (mPuPendV && (!drvEn || !drvData)) begin mPu = mPuPend; mPuPendV = 0; end
      if (mPdPendV && (!drvEn ||  drvData)) begin mPd = mPdPend; mPdPendV = 0; end
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tag, "puCode", int'(puCode), mPu);
    check(tag, "pdCode", int'(pdCode), mPd);
  endtask

  task automatic steps(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic waitEval(string tag);
    for (int i = 0; i < PERIOD + 1; i++) begin
      step(tag);
      if (mLastEval) break;
    end
  endtask

  task automatic setReq(bit pi, bit pd_, bit pi2, bit pd2);
    puInc = pi; puDec = pd_; pdInc = pi2; pdDec = pd2;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R2 watchdog expired: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int rng;
    repeat (3) @(negedge clk);
    check("R1", "puCode in reset", int'(puCode), MID);
    check("R1", "pdCode in reset", int'(pdCode), MID);
    rstN = 1'b1;

    // R2/R9: no change before the first evaluation, then one step
    setReq(1, 0, 0, 1);
    steps("R2", PERIOD - 1);
    check("R1", "puCode before first eval", int'(puCode), MID);
    step("R9");                              // evaluation edge
    check("R9", "puCode on eval edge", int'(puCode), MID);
    step("R9");
    check("R2", "puCode after first commit", int'(puCode), MID + 1);
    check("R2", "pdCode after first commit", int'(pdCode), MID - 1);

    // R4: saturate high then low in high impedance
    setReq(1, 0, 1, 0);
    steps("R4", PERIOD * 10);
    check("R4", "puCode saturated high", int'(puCode), CMAX);
    check("R4", "pdCode saturated high", int'(pdCode), CMAX);
    setReq(0, 1, 0, 1);
    steps("R4", PERIOD * 10);
    check("R4", "puCode saturated low", int'(puCode), 0);
    check("R4", "pdCode saturated low", int'(pdCode), 0);

    // R3: both / neither flags hold
    setReq(1, 1, 1, 1);
    steps("R3", PERIOD * 3);
    setReq(0, 0, 0, 0);
    steps("R3", PERIOD * 3);
    check("R3", "puCode held", int'(puCode), 0);
    check("R3", "pdCode held", int'(pdCode), 0);

    // R5/R6: driving 0 blocks pull-down, lets pull-up move
    drvEn = 1'b1; drvData = 1'b0;
    setReq(1, 0, 1, 0);
    steps("R5", PERIOD * 4);
    check("R5", "pdCode blocked while driving 0", int'(pdCode), 0);
    drvData = 1'b1;
    setReq(0, 0, 1, 0);
    steps("R6", PERIOD * 3);
    base = int'(puCode);
    steps("R6", PERIOD * 2);
    check("R6", "puCode blocked while driving 1", int'(puCode), base);

    // R7: waiting candidate replaced by newer evaluation
    drvData = 1'b0;
    waitEval("R7");
    step("R7");
    base = int'(pdCode);
    setReq(0, 0, 1, 0);
    waitEval("R7");
    setReq(0, 0, 0, 1);
    waitEval("R7");
    setReq(0, 0, 0, 0);
    drvEn = 1'b0;
    steps("R7", 2);
    check("R7", "pdCode after replaced candidate", int'(pdCode), (base > 0) ? base - 1 : 0);

    // R8: flags between evaluations ignored
    waitEval("R8");
    step("R8");
    base = int'(puCode);
    for (int i = 0; i < PERIOD - 2; i++) begin
      setReq(i[0], !i[0], 1, 0);
      step("R8");
    end
    setReq(0, 0, 0, 0);
    steps("R8", 3);
    check("R8", "puCode ignores off-edge flags", int'(puCode), base);

    // Sweep of all input combinations against the reference
    rng = 32'h1d2c3b4a;
    for (int i = 0; i < 600; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >>> 17); rng = rng ^ (rng << 5);
      {drvEn, drvData, puInc, puDec, pdInc, pdDec} = 6'(rng);
      step("R2/R3/R4/R5/R6/R7/R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule